// File: doc/BRIEF.md
# Pipeline Hazard Forwarding and Stall Unit

This block resolves register read-after-write hazards in a five-stage in-order pipeline. The stages are fetch, decode/operand read, ALU, data memory and register write. Each cycle it compares the two source register indices of the instruction in decode with the destination indices of the instructions now in the ALU, memory and write stages. It then picks a bypass source for each operand. All register writes happen in the last stage and in issue order, so write-after-write and write-after-read hazards cannot arise and are not handled.

The block knows, for each instruction class, when a producer's value exists and when a consumer needs it. ALU, load-address and link results exist at the output of the ALU stage. Loaded data exists only at the output of the memory stage. Branch operands are consumed in decode. Store data is consumed in the memory stage. All other operands are consumed in the ALU stage. When no bypass can deliver a value in time, the block pauses fetch and decode and requests a nop in the ALU stage. Both outputs come from combinational logic on the current stage contents. Clock and reset serve only the built-in property checks.

Top module: `hz_unit`

## Requirements
- R1: When no write enable is set in the ALU, memory or write stage, both operand selects read 0 and stall and bubble are low.
- R2: The select code means: 0 = register file, 1 = ALU-stage producer, 2 = memory-stage producer, 3 = write-stage producer. A producer matches an operand only when its write enable is set and its destination index equals the source index. Index 0 behaves like any other register. The class codes are: 0 none, 1 ALU, 2 load, 3 load-address, 4 branch-and-link, 5 store, 6 branch.
- R3: When several stages match the same source, the youngest one wins: ALU stage over memory stage, and memory stage over write stage.
- R4: An ALU-class consumer of an ALU, load-address or link result from the adjacent older instruction gets select 1 and causes no stall.
- R5: An ALU-class consumer of a load result stalls while the load is in the ALU stage. Once the load is in the memory stage, the consumer gets select 2 with no stall.
- R6: A branch or branch-and-link using a load result stalls while the load is in the ALU or memory stage. With the load in the write stage, it gets select 3 and does not stall.
- R7: A branch using an ALU, load-address or link result stalls while that producer is in the ALU stage. With the producer in the memory stage, it gets select 2 and does not stall.
- R8: For a store, the data operand (source B) from a load in the ALU stage gets select 1 with no stall. The address operand (source A) in the same position stalls.
- R9: An operand whose use flag is low, or any operand of class 0, never stalls and reads select 0.
- R10: Bubble equals stall in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| dec_class | input | 3 | Class of the instruction in decode |
| dec_use_a | input | 1 | Source A is read by the decode instruction |
| dec_use_b | input | 1 | Source B is read by the decode instruction |
| dec_src_a | input | REG_W | Source A register index |
| dec_src_b | input | REG_W | Source B register index |
| ex_class | input | 3 | Class of the instruction in the ALU stage |
| ex_dst | input | REG_W | Destination index in the ALU stage |
| ex_we | input | 1 | ALU-stage instruction writes a register |
| mem_class | input | 3 | Class of the instruction in the memory stage |
| mem_dst | input | REG_W | Destination index in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination index in the write stage |
| wb_we | input | 1 | Write-stage instruction writes a register |
| fwd_sel_a | output | 2 | Bypass select for source A |
| fwd_sel_b | output | 2 | Bypass select for source B |
| stall | output | 1 | Pause for fetch and decode |
| bubble | output | 1 | Insert a nop into the ALU stage |

## Verification
Directed sequences place a producer of each class in each of the three older stages, against consumers of ALU, store and branch class. This separates the one-slot load delay, the two-slot load-to-branch delay and the one-slot ALU-to-branch delay from the cases that forwarding covers. Cases where several stages write the same register tell the youngest-wins priority apart from a wrong order. Index 0, cleared write enables and cleared use flags show that a match needs both an equal index and an enabled write. Store operands split the late-needed data path from the address path.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [2:0] {
        CL_NONE   = 3'd0,
        CL_ALU    = 3'd1,
        CL_LOAD   = 3'd2,
        CL_LADR   = 3'd3,
        CL_LINK   = 3'd4,
        CL_STORE  = 3'd5,
        CL_BRANCH = 3'd6
    } iclass_e;

    typedef enum logic [1:0] {
        FW_RF = 2'd0,
        FW_S3 = 2'd1,
        FW_S4 = 2'd2,
        FW_S5 = 2'd3
    } fwsel_e;

    localparam int ST_DEC = 2;
    localparam int ST_ALU = 3;
    localparam int ST_MEM = 4;
    localparam int ST_WB  = 5;

    // stage at whose output a producer's value first exists
    function automatic int ready_stage(input iclass_e c);
        return (c == CL_LOAD) ? ST_MEM : ST_ALU;
    endfunction
endpackage

// File: rtl/hz_need.sv
module hz_need
    import hz_pkg::*;
(
    input  logic [2:0] dec_class,
    input  logic       use_a,
    input  logic       use_b,
    output logic [2:0] need_a,
    output logic [2:0] need_b
);
    iclass_e cls;
    assign cls = iclass_e'(dec_class);

    // need value: stage in which the operand must be present, 0 = unused
    always_comb begin
        need_a = 3'd0;
        need_b = 3'd0;
        unique case (cls)
            CL_BRANCH, CL_LINK: begin
                need_a = 3'(ST_DEC);
                need_b = 3'(ST_DEC);
            end
            CL_STORE: begin
                need_a = 3'(ST_ALU);
                need_b = 3'(ST_MEM);
            end
            CL_ALU, CL_LOAD, CL_LADR: begin
                need_a = 3'(ST_ALU);
                need_b = 3'(ST_ALU);
            end
            default: begin
                need_a = 3'd0;
                need_b = 3'd0;
            end
        endcase
        if (!use_a) need_a = 3'd0;
        if (!use_b) need_b = 3'd0;
    end
endmodule

// File: rtl/hz_operand.sv
module hz_operand
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src,
    input  logic [2:0]       need,
    input  logic [2:0]       ex_cls,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_we,
    input  logic [2:0]       mem_cls,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic [1:0]       sel,
    output logic             hold
);
    logic used, hit_ex, hit_mem, hit_wb;
    int   need_i;

    assign used    = (need != 3'd0);
    assign need_i  = int'(need);
    assign hit_ex  = used && ex_we  && (ex_dst  == src);
    assign hit_mem = used && mem_we && (mem_dst == src);
    assign hit_wb  = used && wb_we  && (wb_dst  == src);

    // A producer in stage p reaches stage p + need - 2 when the consumer
    // reaches its need stage; it must have finished its ready stage by then.
    always_comb begin
        sel  = FW_RF;
        hold = 1'b0;
        if (hit_ex) begin
            sel  = FW_S3;
            hold = (ST_ALU + need_i - 3) < ready_stage(iclass_e'(ex_cls));
        end else if (hit_mem) begin
            sel  = FW_S4;
            hold = (ST_MEM + need_i - 3) < ready_stage(iclass_e'(mem_cls));
        end else if (hit_wb) begin
            sel  = FW_S5;
            hold = 1'b0;
        end
    end

    p_sel_s3_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FW_S3) |-> (ex_we && ex_dst == src));
    p_mem_over_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (need != 3'd0 && !(ex_we && ex_dst == src) && mem_we && mem_dst == src
         && wb_we && wb_dst == src) |-> (sel == FW_S4));
    p_unused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (need == 3'd0) |-> (sel == FW_RF && !hold));
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       dec_class,
    input  logic             dec_use_a,
    input  logic             dec_use_b,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [2:0]       ex_class,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_we,
    input  logic [2:0]       mem_class,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             stall,
    output logic             bubble
);
    localparam int NOPS = 2;

    logic [2:0]       need_v [NOPS];
    logic [REG_W-1:0] src_v  [NOPS];
    logic [1:0]       sel_v  [NOPS];
    logic [NOPS-1:0]  hold_v;

    hz_need u_need (
        .dec_class (dec_class),
        .use_a     (dec_use_a),
        .use_b     (dec_use_b),
        .need_a    (need_v[0]),
        .need_b    (need_v[1])
    );

    assign src_v[0] = dec_src_a;
    assign src_v[1] = dec_src_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_operand #(.REG_W(REG_W)) u_op (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_v[g]),
            .need    (need_v[g]),
            .ex_cls  (ex_class),
            .ex_dst  (ex_dst),
            .ex_we   (ex_we),
            .mem_cls (mem_class),
            .mem_dst (mem_dst),
            .mem_we  (mem_we),
            .wb_dst  (wb_dst),
            .wb_we   (wb_we),
            .sel     (sel_v[g]),
            .hold    (hold_v[g])
        );
    end

    assign fwd_sel_a = sel_v[0];
    assign fwd_sel_b = sel_v[1];
    assign stall     = |hold_v;
    assign bubble    = |hold_v;

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we && !wb_we) |-> (!stall && fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));
    p_load_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_class == 3'd1 && dec_use_a && ex_we && ex_class == 3'd2 && ex_dst == dec_src_a)
        |-> stall);
    p_wb_never_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we) |-> !stall);
    p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall);
endmodule

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
    localparam int RW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] dec_class, ex_class, mem_class;
    logic dec_use_a, dec_use_b, ex_we, mem_we, wb_we;
    logic [RW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic stall, bubble;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    hz_unit #(.REG_W(RW)) u0 (.*);

    // ---- reference: separation needed, in slots, between producer and consumer
    function automatic int sep_needed(input logic [2:0] pc, input int need);
        if (pc == 3'd2) return (need == 2) ? 3 : ((need == 3) ? 2 : 1);
        return (need == 2) ? 2 : 1;
    endfunction

    function automatic int need_of(input logic [2:0] c, input logic u, input int which);
        if (!u || c == 3'd0) return 0;
        if (c == 3'd6 || c == 3'd4) return 2;
        if (c == 3'd5 && which == 1) return 4;
        return 3;
    endfunction

    task automatic model_op(input logic [RW-1:0] s, input int need,
                            output logic [1:0] es, output logic eh);
        es = 2'd0; eh = 1'b0;
        if (need == 0) return;
        if (ex_we && ex_dst == s) begin
            es = 2'd1; eh = (1 < sep_needed(ex_class, need));
        end else if (mem_we && mem_dst == s) begin
            es = 2'd2; eh = (2 < sep_needed(mem_class, need));
        end else if (wb_we && wb_dst == s) begin
            es = 2'd3;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        logic [1:0] sa, sb; logic ha, hb;
        model_op(dec_src_a, need_of(dec_class, dec_use_a, 0), sa, ha);
        model_op(dec_src_b, need_of(dec_class, dec_use_b, 1), sb, hb);
        chk(req, "sel_a", fwd_sel_a, sa);
        chk(req, "sel_b", fwd_sel_b, sb);
        chk(req, "stall", stall, ha | hb);
        chk("R10", "bubble", bubble, stall);
    endtask

    task automatic setup(input logic [2:0] dc, input logic ua, input logic ub,
                         input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                         input logic [2:0] ec, input logic [RW-1:0] ed, input logic ew,
                         input logic [2:0] mc, input logic [RW-1:0] md, input logic mw,
                         input logic [RW-1:0] wd, input logic ww);
        @(negedge clk);
        dec_class = dc; dec_use_a = ua; dec_use_b = ub; dec_src_a = sa; dec_src_b = sb;
        ex_class = ec; ex_dst = ed; ex_we = ew;
        mem_class = mc; mem_dst = md; mem_we = mw;
        wb_dst = wd; wb_we = ww;
        #1;
    endtask

    task automatic t_idle_r1();
        setup(3'd1, 1, 1, 5'd3, 5'd4, 3'd1, 5'd3, 0, 3'd2, 5'd4, 0, 5'd3, 0);
        chk("R1", "sel_a", fwd_sel_a, 0);
        chk("R1", "sel_b", fwd_sel_b, 0);
        chk("R1", "stall", stall, 0);
        chk("R1", "bubble", bubble, 0);
    endtask

    task automatic t_match_r2();
        setup(3'd1, 1, 1, 5'd0, 5'd7, 3'd1, 5'd0, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R2", "sel_a r0", fwd_sel_a, 1);
        chk("R2", "sel_b", fwd_sel_b, 0);
        setup(3'd1, 1, 1, 5'd9, 5'd9, 3'd1, 5'd8, 1, 3'd1, 5'd10, 1, 5'd9, 1);
        chk("R2", "sel_a wb", fwd_sel_a, 3);
        chk_model("R2");
    endtask

    task automatic t_youngest_r3();
        setup(3'd1, 1, 1, 5'd6, 5'd11, 3'd1, 5'd6, 1, 3'd1, 5'd6, 1, 5'd6, 1);
        chk("R3", "sel_a ex wins", fwd_sel_a, 1);
        setup(3'd1, 1, 1, 5'd6, 5'd11, 3'd1, 5'd2, 1, 3'd1, 5'd6, 1, 5'd6, 1);
        chk("R3", "sel_a mem wins", fwd_sel_a, 2);
        setup(3'd1, 1, 1, 5'd6, 5'd6, 3'd2, 5'd6, 1, 3'd1, 5'd6, 1, 5'd6, 1);
        chk("R3", "stall by youngest load", stall, 1);
        chk_model("R3");
    endtask

    task automatic t_alu_chain_r4();
        for (int k = 0; k < 3; k++) begin
            logic [2:0] pc;
            pc = (k == 0) ? 3'd1 : ((k == 1) ? 3'd3 : 3'd4);
            setup(3'd1, 1, 1, 5'd12, 5'd13, pc, 5'd13, 1, 3'd0, 5'd0, 0, 5'd0, 0);
            chk("R4", "sel_b", fwd_sel_b, 1);
            chk("R4", "stall", stall, 0);
        end
    endtask

    task automatic t_load_use_r5();
        setup(3'd1, 1, 1, 5'd2, 5'd5, 3'd2, 5'd2, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R5", "stall", stall, 1);
        chk("R5", "bubble", bubble, 1);
        setup(3'd1, 1, 1, 5'd2, 5'd5, 3'd1, 5'd20, 1, 3'd2, 5'd2, 1, 5'd0, 0);
        chk("R5", "sel_a", fwd_sel_a, 2);
        chk("R5", "stall late", stall, 0);
    endtask

    task automatic t_load_branch_r6();
        setup(3'd6, 1, 1, 5'd15, 5'd16, 3'd2, 5'd15, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R6", "stall ld in s3", stall, 1);
        setup(3'd4, 1, 1, 5'd15, 5'd16, 3'd0, 5'd0, 0, 3'd2, 5'd15, 1, 5'd0, 0);
        chk("R6", "stall ld in s4", stall, 1);
        setup(3'd6, 1, 1, 5'd15, 5'd16, 3'd0, 5'd0, 0, 3'd0, 5'd0, 0, 5'd16, 1);
        chk("R6", "sel_b", fwd_sel_b, 3);
        chk("R6", "stall ld in s5", stall, 0);
    endtask

    task automatic t_alu_branch_r7();
        setup(3'd6, 1, 1, 5'd21, 5'd22, 3'd3, 5'd21, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R7", "stall", stall, 1);
        setup(3'd6, 1, 1, 5'd21, 5'd22, 3'd0, 5'd0, 0, 3'd1, 5'd21, 1, 5'd0, 0);
        chk("R7", "sel_a", fwd_sel_a, 2);
        chk("R7", "stall", stall, 0);
    endtask

    task automatic t_store_r8();
        setup(3'd5, 1, 1, 5'd1, 5'd14, 3'd2, 5'd14, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R8", "sel_b", fwd_sel_b, 1);
        chk("R8", "stall data", stall, 0);
        setup(3'd5, 1, 1, 5'd14, 5'd1, 3'd2, 5'd14, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R8", "stall addr", stall, 1);
    endtask

    task automatic t_unused_r9();
        setup(3'd1, 0, 0, 5'd2, 5'd2, 3'd2, 5'd2, 1, 3'd2, 5'd2, 1, 5'd2, 1);
        chk("R9", "sel_a", fwd_sel_a, 0);
        chk("R9", "sel_b", fwd_sel_b, 0);
        chk("R9", "stall", stall, 0);
        setup(3'd0, 1, 1, 5'd2, 5'd2, 3'd2, 5'd2, 1, 3'd0, 5'd0, 0, 5'd0, 0);
        chk("R9", "stall none", stall, 0);
        chk("R9", "sel_a none", fwd_sel_a, 0);
    endtask

    task automatic t_sweep_r10();
        for (int dc = 0; dc < 7; dc++)
            for (int pc = 0; pc < 7; pc++)
                for (int st = 0; st < 3; st++) begin
                    setup(3'(dc), 1, 1, 5'd3, 5'd4, 3'(pc), 5'd3, st == 0,
                          3'(pc), 5'd4, st == 1, 5'd3, st == 2);
                    chk_model("R10");
                end
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        dec_class = 0; dec_use_a = 0; dec_use_b = 0; dec_src_a = 0; dec_src_b = 0;
        ex_class = 0; ex_dst = 0; ex_we = 0; mem_class = 0; mem_dst = 0; mem_we = 0;
        wb_dst = 0; wb_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle_r1();
        t_match_r2();
        t_youngest_r3();
        t_alu_chain_r4();
        t_load_use_r5();
        t_load_branch_r6();
        t_alu_branch_r7();
        t_store_r8();
        t_unused_r9();
        t_sweep_r10();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule